// File: doc/BRIEF.md
# Read-Triggered 8-bit Arithmetic Unit

This block is the arithmetic and logic unit of a processor whose only instruction is a move. Software loads two operand registers, A and B, by writing to them, and it obtains a result by reading from one of many source addresses. Each source address stands for one computed function of A and B: sum, difference, bitwise combinations, shifts, comparisons, product bytes, quotient and remainder. No opcode register is involved; the read address alone selects the function.

Some reads also update state. Reading a sum records its carry, reading a difference records its borrow, and reading a shift records the bits shifted out. Each of these values stays until the next read of the same family. Each can then be read back as a result, or used by the chained add and subtract functions. This allows wide arithmetic and rotates to be built out of byte-wide moves. Results are registered. A read issued on one clock edge presents its value on `rd_data` after that edge and holds it until the next read.

Top module: `tt_alu`

## Requirements
- R1: A write with `wr_en`=1 loads `wr_data` into operand A when `wr_sel`=0 and into operand B when `wr_sel`=1. Reading source code 0 returns A and source code 1 returns B. A read sampled at a clock edge drives its result on `rd_data` after that same edge.
- R2: Source 2 returns (A+B) mod 256 and saves the carry out. Source 3 returns (A+B+c) mod 256, where c is the saved carry, and saves the new carry out. Source 4 returns the saved carry as 0x00 or 0x01.
- R3: Source 5 returns (A−B) mod 256 and saves the borrow (1 when A<B). Source 6 returns (A−B−b) mod 256, where b is the saved borrow, and saves the new borrow. Source 7 returns the saved borrow as 0x00 or 0x01. The borrow is stored separately from the carry.
- R4: Sources 8, 9 and 10 return A AND B, A OR B and A XOR B.
- R5: Source 11 returns A shifted left by n bits and source 12 returns A shifted right by n bits, both filling with zeros, where n = B[2:0].
- R6: A read of source 11 saves the top n bits of A in the low n bits of the left remainder. A read of source 12 saves the low n bits of A in the top n bits of the right remainder. When n=0, the saved remainder is 0. Source 13 returns the left remainder and source 14 returns the right remainder.
- R7: Sources 15 to 20 return 0x01 when the comparison holds and 0x00 when it does not. In order, the comparisons are A==B, A!=B, A<B, A>B, A<=B and A>=B. All comparisons are unsigned.
- R8: Source 21 returns the low byte and source 22 the high byte of the 16-bit product A×B.
- R9: Source 23 returns A/B and source 24 returns A mod B. When B=0, source 23 returns 0xFF and source 24 returns A.
- R10: The saved carry, borrow and remainders change only on an edge where their own source is read: carry on 2 and 3, borrow on 5 and 6, left remainder on 11, right remainder on 12. Reading any other code leaves them unchanged. Codes 25 to 31 return 0x00.
- R11: Synchronous active-high reset clears A, B, the carry, the borrow, both remainders and `rd_data` to 0.
- R12: `rd_data` holds its value on every edge without a read, including edges with operand writes. A read uses the operand values from before its edge, even when a write to that operand happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | Operand select: 0 = A, 1 = B |
| wr_data | input | 8 | Operand write value |
| rd_en | input | 1 | Result read strobe |
| rd_sel | input | 5 | Source address selecting the result |
| rd_data | output | 8 | Registered result of the last read |

## Verification
The assertions check, on every cycle, the rules that relate state to strobes:
- the result holds on edges without a read;
- each piece of saved side state is disturbed only by its own read;
- operand writes land in the register they select;
- comparison reads return only 0x00 or 0x01, and the equality read matches the operands;
- reading the carry returns exactly the saved bit;
- division by zero returns all ones.

Only the bench scenarios can show the arithmetic itself. This covers chained carry and borrow across several reads and the placement of shifted-out bits. It also covers the unsigned ordering of values with the top bit set, product bytes, the quotient and remainder values, and the ordering of a read against a write on the same edge.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;
  localparam int SRC_W = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_OPA    = 5'd0,
    SRC_OPB    = 5'd1,
    SRC_ADD    = 5'd2,
    SRC_ADC    = 5'd3,
    SRC_CARRY  = 5'd4,
    SRC_SUB    = 5'd5,
    SRC_SBC    = 5'd6,
    SRC_BORROW = 5'd7,
    SRC_AND    = 5'd8,
    SRC_OR     = 5'd9,
    SRC_XOR    = 5'd10,
    SRC_SLL    = 5'd11,
    SRC_SRL    = 5'd12,
    SRC_LREM   = 5'd13,
    SRC_RREM   = 5'd14,
    SRC_EQ     = 5'd15,
    SRC_NE     = 5'd16,
    SRC_LT     = 5'd17,
    SRC_GT     = 5'd18,
    SRC_LE     = 5'd19,
    SRC_GE     = 5'd20,
    SRC_MULLO  = 5'd21,
    SRC_MULHI  = 5'd22,
    SRC_DIV    = 5'd23,
    SRC_MOD    = 5'd24
  } src_e;

  typedef struct packed {
    logic eq;
    logic ne;
    logic lt;
    logic gt;
    logic le;
    logic ge;
  } cmp_t;
endpackage

// File: rtl/tt_alu_operands.sv
module tt_alu_operands #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opa <= '0;
      opb <= '0;
    end else if (wr_en) begin
      if (wr_sel) opb <= wr_data;
      else        opa <= wr_data;
    end
  end
endmodule

// File: rtl/tt_alu_addsub.sv
module tt_alu_addsub #(
  parameter int W = 8
) (
  input  logic         [W-1:0] opa,
  input  logic         [W-1:0] opb,
  input  logic                 cin,
  input  logic                 bin,
  output logic         [W-1:0] add_sum,
  output logic                 add_cout,
  output logic         [W-1:0] adc_sum,
  output logic                 adc_cout,
  output logic         [W-1:0] sub_diff,
  output logic                 sub_bout,
  output logic         [W-1:0] sbc_diff,
  output logic                 sbc_bout,
  output tt_alu_pkg::cmp_t     cmp
);
  logic [W:0] add_w, adc_w, sub_w, sbc_w;

  always_comb begin
    add_w = {1'b0, opa} + {1'b0, opb};
    adc_w = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
    sub_w = {1'b0, opa} - {1'b0, opb};
    sbc_w = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, bin};
    add_sum  = add_w[W-1:0];
    add_cout = add_w[W];
    adc_sum  = adc_w[W-1:0];
    adc_cout = adc_w[W];
    sub_diff = sub_w[W-1:0];
    sub_bout = sub_w[W];
    sbc_diff = sbc_w[W-1:0];
    sbc_bout = sbc_w[W];
    cmp.eq = (opa == opb);
    cmp.ne = !cmp.eq;
    cmp.lt = sub_bout;
    cmp.ge = !sub_bout;
    cmp.gt = !sub_bout && !cmp.eq;
    cmp.le = sub_bout || cmp.eq;
  end
endmodule

// File: rtl/tt_alu_shift.sv
module tt_alu_shift #(
  parameter int W   = 8,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   opa,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   sll_out,
  output logic [W-1:0]   sll_rem,
  output logic [W-1:0]   srl_out,
  output logic [W-1:0]   srl_rem
);
  logic [2*W-1:0] lwide, rwide;

  always_comb begin
    lwide   = {{W{1'b0}}, opa} << amt;
    rwide   = {opa, {W{1'b0}}} >> amt;
    sll_out = lwide[W-1:0];
    sll_rem = lwide[2*W-1:W];
    srl_out = rwide[2*W-1:W];
    srl_rem = rwide[W-1:0];
  end
endmodule

// File: rtl/tt_alu_muldiv.sv
module tt_alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mul_lo,
  output logic [W-1:0] mul_hi,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod   = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
    mul_lo = prod[W-1:0];
    mul_hi = prod[2*W-1:W];
    if (opb == '0) begin
      quo = '1;
      rem = opa;
    end else begin
      quo = opa / opb;
      rem = opa % opb;
    end
  end
endmodule

// File: rtl/tt_alu.sv
module tt_alu #(
  parameter int W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  input  logic [tt_alu_pkg::SRC_W-1:0] rd_sel,
  output logic [W-1:0]                 rd_data
);
  import tt_alu_pkg::*;

  localparam int SHW = $clog2(W);

  logic [W-1:0] opa, opb;
  logic         carry_q, borrow_q;
  logic [W-1:0] lrem_q, rrem_q;

  logic [W-1:0] add_sum, adc_sum, sub_diff, sbc_diff;
  logic         add_cout, adc_cout, sub_bout, sbc_bout;
  cmp_t         cmp;
  logic [W-1:0] sll_out, sll_rem, srl_out, srl_rem;
  logic [W-1:0] mul_lo, mul_hi, quo, rem;
  logic [W-1:0] res;
  src_e         sel;

  tt_alu_operands #(.W(W)) u_ops (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .opa(opa), .opb(opb)
  );

  tt_alu_addsub #(.W(W)) u_addsub (
    .opa(opa), .opb(opb), .cin(carry_q), .bin(borrow_q),
    .add_sum(add_sum), .add_cout(add_cout),
    .adc_sum(adc_sum), .adc_cout(adc_cout),
    .sub_diff(sub_diff), .sub_bout(sub_bout),
    .sbc_diff(sbc_diff), .sbc_bout(sbc_bout),
    .cmp(cmp)
  );

  tt_alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .opa(opa), .amt(opb[SHW-1:0]),
    .sll_out(sll_out), .sll_rem(sll_rem),
    .srl_out(srl_out), .srl_rem(srl_rem)
  );

  tt_alu_muldiv #(.W(W)) u_muldiv (
    .opa(opa), .opb(opb),
    .mul_lo(mul_lo), .mul_hi(mul_hi), .quo(quo), .rem(rem)
  );

  function automatic logic [W-1:0] bit2w(input logic b);
    return {{(W-1){1'b0}}, b};
  endfunction

  always_comb begin
    sel = src_e'(rd_sel);
    unique case (sel)
      SRC_OPA:    res = opa;
      SRC_OPB:    res = opb;
      SRC_ADD:    res = add_sum;
      SRC_ADC:    res = adc_sum;
      SRC_CARRY:  res = bit2w(carry_q);
      SRC_SUB:    res = sub_diff;
      SRC_SBC:    res = sbc_diff;
      SRC_BORROW: res = bit2w(borrow_q);
      SRC_AND:    res = opa & opb;
      SRC_OR:     res = opa | opb;
      SRC_XOR:    res = opa ^ opb;
      SRC_SLL:    res = sll_out;
      SRC_SRL:    res = srl_out;
      SRC_LREM:   res = lrem_q;
      SRC_RREM:   res = rrem_q;
      SRC_EQ:     res = bit2w(cmp.eq);
      SRC_NE:     res = bit2w(cmp.ne);
      SRC_LT:     res = bit2w(cmp.lt);
      SRC_GT:     res = bit2w(cmp.gt);
      SRC_LE:     res = bit2w(cmp.le);
      SRC_GE:     res = bit2w(cmp.ge);
      SRC_MULLO:  res = mul_lo;
      SRC_MULHI:  res = mul_hi;
      SRC_DIV:    res = quo;
      SRC_MOD:    res = rem;
      default:    res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
      lrem_q   <= '0;
      rrem_q   <= '0;
    end else if (rd_en) begin
      rd_data <= res;
      case (sel)
        SRC_ADD: carry_q  <= add_cout;
        SRC_ADC: carry_q  <= adc_cout;
        SRC_SUB: borrow_q <= sub_bout;
        SRC_SBC: borrow_q <= sbc_bout;
        SRC_SLL: lrem_q   <= sll_rem;
        SRC_SRL: rrem_q   <= srl_rem;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tt_alu_chk.sv
module tt_alu_chk #(
  parameter int W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic                         wr_sel,
  input logic [W-1:0]                 wr_data,
  input logic                         rd_en,
  input logic [tt_alu_pkg::SRC_W-1:0] rd_sel,
  input logic [W-1:0]                 rd_data,
  input logic [W-1:0]                 opa,
  input logic [W-1:0]                 opb,
  input logic                         carry_q,
  input logic                         borrow_q,
  input logic [W-1:0]                 lrem_q,
  input logic [W-1:0]                 rrem_q
);
  import tt_alu_pkg::*;

  localparam int SHW = $clog2(W);

  // R1: operand writes land in the selected register
  p_load_a_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_sel |=> opa == $past(wr_data));
  p_load_b_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel |=> opb == $past(wr_data));

  // R12: result holds without a read
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R10: side state disturbed only by its own read
  p_carry_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (rd_sel == SRC_ADD || rd_sel == SRC_ADC)) |=> $stable(carry_q));
  p_borrow_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (rd_sel == SRC_SUB || rd_sel == SRC_SBC)) |=> $stable(borrow_q));
  p_lrem_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_sel == SRC_SLL) |=> $stable(lrem_q));
  p_rrem_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && rd_sel == SRC_SRL) |=> $stable(rrem_q));

  // R7: comparisons give a clean 0 or 1, equality matches operands
  p_cmp_bool_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel >= SRC_EQ && rd_sel <= SRC_GE |=> rd_data <= 1);
  p_eq_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel == SRC_EQ |=> rd_data[0] == ($past(opa) == $past(opb)));

  // R2: carry source mirrors the saved bit
  p_carry_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel == SRC_CARRY |=> rd_data == {{(W-1){1'b0}}, $past(carry_q)});

  // R6: zero shift amount leaves an empty remainder
  p_lrem_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel == SRC_SLL && opb[SHW-1:0] == '0 |=> lrem_q == '0);

  // R9: quotient by zero is all ones
  p_div0_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel == SRC_DIV && opb == '0 |=> rd_data == '1);
endmodule

bind tt_alu tt_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .opa(opa), .opb(opb), .carry_q(carry_q), .borrow_q(borrow_q),
  .lrem_q(lrem_q), .rrem_q(rrem_q)
);

// File: tb/tt_alu_tb.sv
`timescale 1ns/1ps
module tt_alu_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [4:0]   rd_sel = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tt_alu u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ops(input logic [W-1:0] a, input logic [W-1:0] b);
    put(1'b0, a);
    put(1'b1, b);
  endtask

  task automatic get(input logic [4:0] s, output logic [W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R11", "rd_data after reset", rd_data, 8'h00);
    get(5'd0, v);  check("R11", "A after reset", v, 8'h00);
    get(5'd4, v);  check("R11", "carry after reset", v, 8'h00);
    get(5'd13, v); check("R11", "left remainder after reset", v, 8'h00);
  endtask

  task automatic t_operands();
    logic [W-1:0] v;
    ops(8'h3C, 8'hA5);
    get(5'd0, v); check("R1", "read A", v, 8'h3C);
    get(5'd1, v); check("R1", "read B", v, 8'hA5);
  endtask

  task automatic t_add();
    logic [W-1:0] v;
    ops(8'hF0, 8'h20);
    get(5'd2, v); check("R2", "ADD F0+20", v, 8'h10);
    get(5'd4, v); check("R2", "carry after overflow", v, 8'h01);
    ops(8'h01, 8'h02);
    get(5'd3, v); check("R2", "ADC 01+02+1", v, 8'h04);
    get(5'd4, v); check("R2", "carry after ADC", v, 8'h00);
    ops(8'hFF, 8'h01);
    get(5'd2, v); check("R2", "ADD FF+01", v, 8'h00);
    get(5'd3, v); check("R2", "ADC FF+01+1", v, 8'h01);
    get(5'd4, v); check("R2", "carry chained", v, 8'h01);
  endtask

  task automatic t_sub();
    logic [W-1:0] v;
    ops(8'h10, 8'h20);
    get(5'd5, v); check("R3", "SUB 10-20", v, 8'hF0);
    get(5'd7, v); check("R3", "borrow set", v, 8'h01);
    get(5'd4, v); check("R3", "carry apart from borrow", v, 8'h01);
    ops(8'h05, 8'h03);
    get(5'd6, v); check("R3", "SBC 05-03-1", v, 8'h01);
    get(5'd7, v); check("R3", "borrow cleared", v, 8'h00);
    ops(8'h00, 8'h01);
    get(5'd5, v); check("R3", "SUB 00-01", v, 8'hFF);
    put(1'b1, 8'h00);
    get(5'd6, v); check("R3", "SBC 00-00-1", v, 8'hFF);
    get(5'd7, v); check("R3", "borrow chained", v, 8'h01);
  endtask

  task automatic t_logic();
    logic [W-1:0] v;
    ops(8'hCA, 8'h5F);
    get(5'd8, v);  check("R4", "AND", v, 8'hCA & 8'h5F);
    get(5'd9, v);  check("R4", "OR", v, 8'hCA | 8'h5F);
    get(5'd10, v); check("R4", "XOR", v, 8'hCA ^ 8'h5F);
  endtask

  task automatic t_shift();
    logic [W-1:0] v;
    ops(8'hB5, 8'h0B);
    get(5'd11, v); check("R5", "SLL by 3 (B=0B)", v, 8'hA8);
    get(5'd13, v); check("R6", "left remainder", v, 8'h05);
    get(5'd12, v); check("R5", "SRL by 3", v, 8'h16);
    get(5'd14, v); check("R6", "right remainder", v, 8'hA0);
    ops(8'h81, 8'h07);
    get(5'd11, v); check("R5", "SLL by 7", v, 8'h80);
    get(5'd13, v); check("R6", "left remainder n=7", v, 8'h40);
    get(5'd14, v); check("R10", "right remainder kept", v, 8'hA0);
    put(1'b1, 8'h08);
    get(5'd12, v); check("R5", "SRL by 0", v, 8'h81);
    get(5'd14, v); check("R6", "right remainder n=0", v, 8'h00);
  endtask

  task automatic t_cmp();
    logic [W-1:0] v;
    ops(8'h80, 8'h01);
    get(5'd15, v); check("R7", "EQ 80,01", v, 8'h00);
    get(5'd16, v); check("R7", "NE 80,01", v, 8'h01);
    get(5'd17, v); check("R7", "LT unsigned 80,01", v, 8'h00);
    get(5'd18, v); check("R7", "GT unsigned 80,01", v, 8'h01);
    ops(8'h42, 8'h42);
    get(5'd15, v); check("R7", "EQ 42,42", v, 8'h01);
    get(5'd19, v); check("R7", "LE 42,42", v, 8'h01);
    get(5'd20, v); check("R7", "GE 42,42", v, 8'h01);
    get(5'd18, v); check("R7", "GT 42,42", v, 8'h00);
    put(1'b1, 8'hFE);
    get(5'd17, v); check("R7", "LT 42,FE", v, 8'h01);
    get(5'd20, v); check("R7", "GE 42,FE", v, 8'h00);
  endtask

  task automatic t_mul();
    logic [W-1:0] v;
    ops(8'hC8, 8'h0F);
    get(5'd21, v); check("R8", "MULLO C8*0F", v, 8'hB8);
    get(5'd22, v); check("R8", "MULHI C8*0F", v, 8'h0B);
    ops(8'hFF, 8'hFF);
    get(5'd22, v); check("R8", "MULHI FF*FF", v, 8'hFE);
  endtask

  task automatic t_div();
    logic [W-1:0] v;
    ops(8'hC8, 8'h07);
    get(5'd23, v); check("R9", "DIV 200/7", v, 8'd28);
    get(5'd24, v); check("R9", "MOD 200%7", v, 8'd4);
    put(1'b1, 8'h00);
    get(5'd23, v); check("R9", "DIV by zero", v, 8'hFF);
    get(5'd24, v); check("R9", "MOD by zero", v, 8'hC8);
  endtask

  task automatic t_sticky();
    logic [W-1:0] v;
    ops(8'hFF, 8'h01);
    get(5'd2, v);
    ops(8'hB5, 8'h03);
    get(5'd11, v);
    get(5'd5, v); get(5'd15, v); get(5'd12, v); get(5'd4, v); get(5'd4, v);
    check("R10", "carry survives other reads", v, 8'h01);
    get(5'd13, v); check("R10", "left remainder survives", v, 8'h05);
    get(5'd31, v); check("R10", "unused code 31", v, 8'h00);
    get(5'd25, v); check("R10", "unused code 25", v, 8'h00);
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    ops(8'h11, 8'h22);
    get(5'd2, v); check("R12", "ADD before hold", v, 8'h33);
    ops(8'h77, 8'h66);
    repeat (3) @(negedge clk);
    check("R12", "held over writes", rd_data, 8'h33);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h99;
    rd_en = 1'b1; rd_sel = 5'd0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R12", "read beside write sees old A", rd_data, 8'h77);
    get(5'd0, v); check("R12", "A after same-edge write", v, 8'h99);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_operands();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_cmp();
    t_mul();
    t_div();
    t_sticky();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule